// File: doc/BRIEF.md
# Multiplexed Pixel Input Demultiplexer

This block sits behind a 12-bit pixel input port on which every 24-bit pixel arrives as two half-words on consecutive rising edges of `clk_i`, which runs at twice the pixel rate. The first half-word of a pixel is called A and the second B. The block rebuilds full pixels from each pair and emits one pixel-valid strobe per pixel. The horizontal sync, vertical sync and data-enable go to the outputs with the same latency as the pixel data.

A 2-bit format code chooses how the pair is read: RGB 12/12, RGB 5-6-5, RGB 5-5-5, or byte-wide multiplexed luma/chroma. In the RGB formats, the data-enable pin frames the pixels. In the luma/chroma format, the block ignores data-enable and finds active video from an embedded start code. When no pixel is valid, the pixel bus carries the black level of the current format. A new format code is adopted only on a rising edge of vertical sync, so a frame is never decoded with two formats.

Top module: `pix_demux`

## Requirements
- R1: While `rst_ni` is low, `pix_o`, `pix_valid_o`, `hsync_o`, `vsync_o` and `de_o` are 0, and the active format is RGB 12/12 (code 0).
- R2: With format code 0 (RGB 12/12), a pixel is `{B[11:4], B[3:0], A[11:8], A[7:0]}`, with bits 23:16 red, 15:8 green and 7:0 blue.
- R3: With format code 1 (RGB 5-6-5), the 16-bit word `{B[7:0], A[7:0]}` holds red in bits 15:11, green in 10:5 and blue in 4:0. Each channel is widened to 8 bits by repeating its top bits below it. `data_i[11:8]` is ignored.
- R4: With format code 2 (RGB 5-5-5), the word `{B[6:0], A[7:0]}` holds red in 14:10, green in 9:5 and blue in 4:0, widened the same way. `B[7]` and `data_i[11:8]` are ignored.
- R5: With format code 3 (luma/chroma), bytes arrive on `data_i[7:0]` in the order Cb, Y, Cr, Y. Each pixel is `{B byte (luma), A byte (chroma), 8'h00}`, so each chroma sample is paired with the luma that follows it. `data_i[11:8]` is ignored.
- R6: `pix_valid_o` goes high for exactly one cycle, in the clock after the B half-word is presented, and is never high on two consecutive cycles. `hsync_o`, `vsync_o` and `de_o` equal their inputs from one clock earlier.
- R7: In the RGB formats, the first cycle with `de_i` high after a cycle with it low always carries an A half-word. An unpaired half-word at the end of a `de_i` burst produces no pixel.
- R8: In format 3, the byte run FF, 00, 00 followed by a status byte with bit 4 = 0 and bit 5 = 0 starts active video, and the next byte is the chroma of the first pixel. Status bits 7, 6 and 3:0 are ignored. A status byte with bit 5 = 1 does not start active video.
- R9: In format 3, a byte of FF during active video ends active video, and no pixel is formed from the pair that contains it. A status byte with bit 4 = 1 also leaves active video off.
- R10: When `pix_valid_o` is low, `pix_o` is 0 in the RGB formats and `{8'd16, 8'd128, 8'd0}` in format 3.
- R11: `fmt_i` is copied into the active format only in a cycle where `vsync_i` is high and was low in the cycle before. The new format applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-word clock (twice the pixel rate) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 12 | Half-word input |
| hsync_i | input | 1 | Horizontal sync in |
| vsync_i | input | 1 | Vertical sync in; its rising edge applies a new format |
| de_i | input | 1 | Data-enable in; frames pixels in the RGB formats |
| fmt_i | input | 2 | Requested format: 0 RGB 12/12, 1 RGB 5-6-5, 2 RGB 5-5-5, 3 luma/chroma |
| pix_o | output | 24 | Rebuilt pixel, or the black level when not valid |
| pix_valid_o | output | 1 | One-cycle strobe per rebuilt pixel |
| hsync_o | output | 1 | Horizontal sync, delayed one clock |
| vsync_o | output | 1 | Vertical sync, delayed one clock |
| de_o | output | 1 | Data-enable, delayed one clock |

## Verification
The assertions check four things on every cycle:
- the pixel strobe is never high on two adjacent cycles;
- an RGB pixel is emitted only after two data-enabled cycles;
- an FF byte in luma/chroma mode never forms a pixel;
- the active format changes only at a vertical sync rising edge.

Only the bench's scenarios can show the following:
- the bit placement of each format;
- the framing on the start code, including the ignored status bits and the blanked-line status;
- the phase restart on a data-enable edge;
- the black levels;
- the exact cycle from which a new format applies.

// File: rtl/pix_demux_pkg.sv
package pix_demux_pkg;
  localparam int HALF_W  = 12;
  localparam int BYTE_W  = 8;
  localparam int PIX_W   = 3 * BYTE_W;
  localparam int FMT_W   = 2;
  localparam int PRE_LEN = 3;

  typedef enum logic [FMT_W-1:0] {
    FMT_RGB_1212 = 2'd0,
    FMT_RGB_565  = 2'd1,
    FMT_RGB_555  = 2'd2,
    FMT_YCC_8    = 2'd3
  } fmt_e;

  localparam logic [BYTE_W-1:0] CODE_FF     = 8'hFF;
  localparam logic [BYTE_W-1:0] CODE_00     = 8'h00;
  localparam logic [BYTE_W-1:0] LUMA_BLACK  = 8'd16;
  localparam logic [BYTE_W-1:0] CHROMA_MID  = 8'd128;

  function automatic logic [BYTE_W-1:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [BYTE_W-1:0] widen6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  function automatic logic [PIX_W-1:0] black_level(input fmt_e f);
    return (f == FMT_YCC_8) ? {LUMA_BLACK, CHROMA_MID, CODE_00} : '0;
  endfunction
endpackage

// File: rtl/pix_demux_fmt.sv
module pix_demux_fmt
  import pix_demux_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vsync_i,
  input  logic [FMT_W-1:0] fmt_i,
  output fmt_e             fmt_o,
  output logic             vs_rise_o
);
  logic vs_q;
  fmt_e fmt_q;

  assign vs_rise_o = vsync_i & ~vs_q;
  assign fmt_o     = fmt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q  <= 1'b0;
      fmt_q <= FMT_RGB_1212;
    end else begin
      vs_q <= vsync_i;
      if (vs_rise_o) fmt_q <= fmt_e'(fmt_i);
    end
  end

  // R11: format only moves at a vsync rising edge
  a_r11_fmt_only_on_vsync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vsync_i && !vs_q) |=> $stable(fmt_q));
endmodule

// File: rtl/pix_demux_codes.sv
module pix_demux_codes
  import pix_demux_pkg::*;
#(
  parameter int W   = BYTE_W,
  parameter int PRE = PRE_LEN
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] byte_i,
  output logic         status_o,
  output logic         sav_o,
  output logic         eav_o,
  output logic         ff_o
);
  localparam int H_BIT = 4;
  localparam int V_BIT = 5;

  logic [W-1:0] hist_q [PRE];
  logic [PRE-1:0] match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PRE; i++) hist_q[i] <= '0;
    end else begin
      hist_q[0] <= byte_i;
      for (int i = 1; i < PRE; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  // oldest entry must be FF, the rest 00
  for (genvar g = 0; g < PRE; g++) begin : g_match
    if (g == PRE - 1) begin : g_lead
      assign match[g] = (hist_q[g] == {W{1'b1}});
    end else begin : g_zero
      assign match[g] = (hist_q[g] == '0);
    end
  end

  assign status_o = &match;
  assign sav_o    = status_o & ~byte_i[H_BIT] & ~byte_i[V_BIT];
  assign eav_o    = status_o & byte_i[H_BIT];
  assign ff_o     = (byte_i == {W{1'b1}});
endmodule

// File: rtl/pix_demux_phase.sv
module pix_demux_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ycc_i,
  input  logic de_i,
  input  logic vs_rise_i,
  input  logic status_i,
  input  logic sav_i,
  input  logic eav_i,
  input  logic ff_i,
  output logic cap_o,
  output logic emit_o
);
  logic de_q, phase_q, active_q;
  logic phase_n, active_n;

  always_comb begin
    cap_o    = 1'b0;
    emit_o   = 1'b0;
    phase_n  = phase_q;
    active_n = active_q;
    if (vs_rise_i) begin
      phase_n  = 1'b0;
      active_n = 1'b0;
    end else if (ycc_i) begin
      if (status_i) begin
        phase_n = 1'b0;
        if (sav_i)      active_n = 1'b1;
        else if (eav_i) active_n = 1'b0;
      end else if (active_q) begin
        if (ff_i) begin
          active_n = 1'b0;
          phase_n  = 1'b0;
        end else if (!phase_q) begin
          cap_o   = 1'b1;
          phase_n = 1'b1;
        end else begin
          emit_o  = 1'b1;
          phase_n = 1'b0;
        end
      end
    end else begin
      if (!de_i) begin
        phase_n = 1'b0;
      end else if (!de_q || !phase_q) begin
        cap_o   = 1'b1;
        phase_n = 1'b1;
      end else begin
        emit_o  = 1'b1;
        phase_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_q     <= 1'b0;
      phase_q  <= 1'b0;
      active_q <= 1'b0;
    end else begin
      de_q     <= de_i;
      phase_q  <= phase_n;
      active_q <= active_n;
    end
  end

  a_r7_rgb_pair_under_de: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ycc_i && emit_o) |-> (de_i && de_q));

  a_r9_ff_never_forms_pixel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ycc_i && ff_i) |-> !emit_o);
endmodule

// File: rtl/pix_demux_out.sv
module pix_demux_out
  import pix_demux_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  fmt_e              fmt_i,
  input  logic              cap_i,
  input  logic              emit_i,
  input  logic [HALF_W-1:0] d_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic              de_i,
  output logic [PIX_W-1:0]  pix_o,
  output logic              valid_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o
);
  logic [HALF_W-1:0] a_q;
  logic [PIX_W-1:0]  packed_pix;

  always_comb begin
    unique case (fmt_i)
      FMT_RGB_1212: packed_pix = {d_i, a_q};
      FMT_RGB_565:  packed_pix = {widen5(d_i[7:3]), widen6({d_i[2:0], a_q[7:5]}),
                                  widen5(a_q[4:0])};
      FMT_RGB_555:  packed_pix = {widen5(d_i[6:2]), widen5({d_i[1:0], a_q[7:5]}),
                                  widen5(a_q[4:0])};
      default:      packed_pix = {d_i[BYTE_W-1:0], a_q[BYTE_W-1:0], CODE_00};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q     <= '0;
      pix_o   <= '0;
      valid_o <= 1'b0;
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      de_o    <= 1'b0;
    end else begin
      if (cap_i) a_q <= d_i;
      pix_o   <= emit_i ? packed_pix : black_level(fmt_i);
      valid_o <= emit_i;
      hsync_o <= hsync_i;
      vsync_o <= vsync_i;
      de_o    <= de_i;
    end
  end
endmodule

// File: rtl/pix_demux.sv
module pix_demux
  import pix_demux_pkg::*;
#(
  parameter int DATA_W = HALF_W,
  parameter int OUT_W  = PIX_W,
  parameter int SEL_W  = FMT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic              de_i,
  input  logic [SEL_W-1:0]  fmt_i,
  output logic [OUT_W-1:0]  pix_o,
  output logic              pix_valid_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o
);
  fmt_e fmt;
  logic vs_rise, status, sav, eav, ff, cap, emit;

  pix_demux_fmt u_fmt (
    .clk_i, .rst_ni, .vsync_i, .fmt_i,
    .fmt_o(fmt), .vs_rise_o(vs_rise)
  );

  pix_demux_codes #(.W(BYTE_W), .PRE(PRE_LEN)) u_codes (
    .clk_i, .rst_ni, .byte_i(data_i[BYTE_W-1:0]),
    .status_o(status), .sav_o(sav), .eav_o(eav), .ff_o(ff)
  );

  pix_demux_phase u_phase (
    .clk_i, .rst_ni, .ycc_i(fmt == FMT_YCC_8), .de_i,
    .vs_rise_i(vs_rise), .status_i(status), .sav_i(sav), .eav_i(eav),
    .ff_i(ff), .cap_o(cap), .emit_o(emit)
  );

  pix_demux_out u_out (
    .clk_i, .rst_ni, .fmt_i(fmt), .cap_i(cap), .emit_i(emit), .d_i(data_i),
    .hsync_i, .vsync_i, .de_i,
    .pix_o, .valid_o(pix_valid_o), .hsync_o, .vsync_o, .de_o
  );

  // R6: two half-words per pixel
  a_r6_valid_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |=> !pix_valid_o);
endmodule

// File: tb/pix_demux_tb_top.sv
module pix_demux_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] data = '0;
  logic        hs = 1'b0, vs = 1'b0, de = 1'b0;
  logic [1:0]  fmt = 2'd0;
  logic [23:0] pix;
  logic        valid, hs_o, vs_o, de_o;
  int n_chk = 0, n_fail = 0;

  localparam logic [23:0] YCC_BLACK = 24'h108000;

  always #5 clk = ~clk;

  pix_demux dut_i (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .hsync_i(hs), .vsync_i(vs),
    .de_i(de), .fmt_i(fmt), .pix_o(pix), .pix_valid_o(valid),
    .hsync_o(hs_o), .vsync_o(vs_o), .de_o(de_o)
  );

  task automatic chk(input bit ok, input string req, input logic [23:0] act,
                     input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [11:0] d, input logic e, input logic h, input logic v);
    @(negedge clk);
    data = d; de = e; hs = h; vs = v;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_pix(input string req, input logic [23:0] exp);
    chk(valid === 1'b1, {req, " valid"}, {23'd0, valid}, 24'd1);
    chk(pix === exp, req, pix, exp);
  endtask

  task automatic expect_idle(input string req, input logic [23:0] blk);
    chk(valid === 1'b0, {req, " no strobe"}, {23'd0, valid}, 24'd0);
    chk(pix === blk, {req, " black"}, pix, blk);
  endtask

  function automatic logic [7:0] grow(input logic [7:0] v, input int bits);
    logic [7:0] r;
    r = v << (8 - bits);
    return r | (r >> bits);
  endfunction

  function automatic logic [23:0] exp565(input logic [11:0] a, input logic [11:0] b);
    logic [15:0] w;
    w = {b[7:0], a[7:0]};
    return {grow({3'd0, w[15:11]}, 5), grow({2'd0, w[10:5]}, 6), grow({3'd0, w[4:0]}, 5)};
  endfunction

  function automatic logic [23:0] exp555(input logic [11:0] a, input logic [11:0] b);
    logic [14:0] w;
    w = {b[6:0], a[7:0]};
    return {grow({3'd0, w[14:10]}, 5), grow({3'd0, w[9:5]}, 5), grow({3'd0, w[4:0]}, 5)};
  endfunction

  task automatic set_fmt(input logic [1:0] f);
    fmt = f;
    drive(12'h000, 1'b0, 1'b0, 1'b1);
    drive(12'h000, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    chk(pix === 24'd0 && valid === 1'b0, "R1 outputs in reset", pix, 24'd0);
    chk({hs_o, vs_o, de_o} === 3'b000, "R1 syncs in reset", {21'd0, hs_o, vs_o, de_o}, 24'd0);
  endtask

  task automatic t_rgb1212;
    drive(12'hA5C, 1'b1, 1'b0, 1'b0);
    chk(valid === 1'b0, "R6 no strobe after A", {23'd0, valid}, 24'd0);
    drive(12'h3F1, 1'b1, 1'b1, 1'b0);
    expect_pix("R2 pixel 1", 24'h3F1A5C);
    chk(hs_o === 1'b1 && de_o === 1'b1, "R6 syncs delayed", {22'd0, hs_o, de_o}, 24'd3);
    drive(12'h0F0, 1'b1, 1'b0, 1'b0);
    chk(valid === 1'b0, "R6 strobe one cycle", {23'd0, valid}, 24'd0);
    drive(12'hC87, 1'b1, 1'b0, 1'b0);
    expect_pix("R2 pixel 2", 24'hC870F0);
    drive(12'h000, 1'b0, 1'b0, 1'b0);
    expect_idle("R10 rgb idle", 24'd0);
  endtask

  task automatic t_de_phase;
    drive(12'h111, 1'b1, 1'b0, 1'b0);
    drive(12'h222, 1'b1, 1'b0, 1'b0);
    expect_pix("R7 first pair", 24'h222111);
    drive(12'h333, 1'b1, 1'b0, 1'b0);
    drive(12'h444, 1'b0, 1'b0, 1'b0);
    expect_idle("R7 odd half-word dropped", 24'd0);
    drive(12'h555, 1'b1, 1'b0, 1'b0);
    chk(valid === 1'b0, "R7 de rise is A", {23'd0, valid}, 24'd0);
    drive(12'h666, 1'b1, 1'b0, 1'b0);
    expect_pix("R7 restart pair", 24'h666555);
    drive(12'h000, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_fmt_switch;
    fmt = 2'd1;
    drive(12'h0B6, 1'b1, 1'b0, 1'b0);
    drive(12'h0D9, 1'b1, 1'b0, 1'b0);
    expect_pix("R11 no switch without vsync", 24'h0D90B6);
    drive(12'h000, 1'b0, 1'b0, 1'b0);
    drive(12'h000, 1'b0, 1'b0, 1'b1);
    chk(vs_o === 1'b1, "R6 vsync delayed", {23'd0, vs_o}, 24'd1);
    drive(12'h000, 1'b0, 1'b0, 1'b0);
    drive(12'hF6B, 1'b1, 1'b0, 1'b0);
    drive(12'hAD9, 1'b1, 1'b0, 1'b0);
    expect_pix("R3 565 after vsync R11", exp565(12'hF6B, 12'hAD9));
    drive(12'h03A, 1'b1, 1'b0, 1'b0);
    drive(12'h0C5, 1'b1, 1'b0, 1'b0);
    expect_pix("R3 565 second", exp565(12'h03A, 12'h0C5));
    drive(12'h000, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_rgb555;
    set_fmt(2'd2);
    drive(12'h7E4, 1'b1, 1'b0, 1'b0);
    drive(12'hF9B, 1'b1, 1'b0, 1'b0);
    expect_pix("R4 555 top bit ignored", exp555(12'h7E4, 12'h01B));
    drive(12'h000, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic ycc_bytes(input logic [7:0] b);
    drive({4'h9, b}, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic preamble(input logic [7:0] status);
    ycc_bytes(8'hFF);
    ycc_bytes(8'h00);
    ycc_bytes(8'h00);
    ycc_bytes(status);
  endtask

  task automatic t_ycc;
    set_fmt(2'd3);
    ycc_bytes(8'h40);
    expect_idle("R10 ycc black", YCC_BLACK);
    ycc_bytes(8'h41);
    chk(valid === 1'b0, "R8 no pixel before start", {23'd0, valid}, 24'd0);
    preamble(8'hCF);
    ycc_bytes(8'h33);
    chk(valid === 1'b0, "R8 chroma first", {23'd0, valid}, 24'd0);
    ycc_bytes(8'hA1);
    expect_pix("R5 R8 pixel 0", 24'hA13300);
    ycc_bytes(8'h55);
    ycc_bytes(8'h6B);
    expect_pix("R5 pixel 1", 24'h6B5500);
    ycc_bytes(8'h22);
    ycc_bytes(8'hFF);
    expect_idle("R9 FF ends line", YCC_BLACK);
    ycc_bytes(8'h00);
    ycc_bytes(8'h00);
    ycc_bytes(8'h90);
    ycc_bytes(8'h44);
    ycc_bytes(8'h45);
    expect_idle("R9 end status keeps idle", YCC_BLACK);
    preamble(8'hA0);
    ycc_bytes(8'h46);
    ycc_bytes(8'h47);
    expect_idle("R8 blanked-line status ignored", YCC_BLACK);
    preamble(8'h00);
    ycc_bytes(8'h10);
    ycc_bytes(8'h20);
    expect_pix("R8 plain start", 24'h201000);
    ycc_bytes(8'hFF);
    expect_idle("R9 FF at A", YCC_BLACK);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    #20;
    @(negedge clk);
    rst_n = 1'b1;
    t_rgb1212();
    t_de_phase();
    t_fmt_switch();
    t_rgb555();
    t_ycc();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule